// File: doc/BRIEF.md
# Channel Status Block Serializer

This block keeps one 192-bit channel-status block for a digital audio transmitter in six 32-bit page words. On every frame it hands one channel-status bit to a subframe encoder. At each frame boundary the transmitter loads a page word into a private shifter and steps through it from the least significant bit upward. It runs through the pages in ascending order and then wraps back to the first page. A busy flag follows the loading of the first and last page words. A status output marks the frame that carries the first bit of the block, so the encoder knows when to insert its block-start preamble.

A receive path runs the other way. It takes the channel-status bit of each received frame and writes it into six words. Bits go in ascending bit order within a word, and the words fill in ascending order. A block-start indication puts the write position back to the first bit. A sticky flag records that a whole block has been collected, and any received word can be read through a small select port. Line coding, preamble generation and any bus interface belong to other blocks.

Top module: `chs_block_serdes`

## Requirements
- R1: After reset, tx_cbit, tx_busy, tx_block_first and rx_block_done are 0 and every receive word reads 0.
- R2: On each tx_frame_stb with tx_enable and cs_enable both high, the serializer presents the next block bit. The first strobe after idle presents page 0 bit 0. Bit j of the block is bit j mod 32 of page j/32. After bit 191 it wraps to page 0 bit 0. tx_block_first is 1 exactly while page 0 bit 0 is presented.
- R3: tx_busy goes to 1 when page 0 is loaded into the shifter, both at the start and at every wrap. It goes to 0 when page 5 (the last page) is loaded.
- R4: A tx_frame_stb that arrives while tx_enable or cs_enable is low stops the serializer and clears tx_busy. The next enabled strobe restarts at page 0 bit 0.
- R5: While cs_enable is low, tx_cbit is 0 in the same cycle.
- R6: A write to a page takes effect only when that page is next loaded into the shifter. A write to the page being shifted does not change the bits still to come from it.
- R7: Without tx_frame_stb the serializer outputs do not change.
- R8: Each rx_frame_stb after synchronisation stores rx_cbit at the current position, from least significant bit upward and from word 0 to word 5. rx_rd_sel = k returns word k.
- R9: rx_block_done becomes 1 on the strobe that stores block bit 191 and stays 1 until rx_done_clr. If both happen in the same cycle, setting wins.
- R10: A strobe with rx_block_start high stores its bit at word 0 bit 0 and continues from bit 1. Strobes before the first such strobe are ignored.
- R11: Writes with cfg_wr_sel of 6 or 7 change no page, and reads with rx_rd_sel of 6 or 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Page write strobe |
| cfg_wr_sel | input | 3 | Page select for writes |
| cfg_wr_data | input | 32 | Page write data |
| tx_enable | input | 1 | Transmitter enable |
| cs_enable | input | 1 | Channel-status insertion enable |
| tx_frame_stb | input | 1 | Transmit frame boundary, one cycle |
| tx_cbit | output | 1 | Channel-status bit for the current frame |
| tx_busy | output | 1 | Block-sequencing busy flag |
| tx_block_first | output | 1 | Current frame carries block bit 0 |
| rx_frame_stb | input | 1 | Receive frame boundary, one cycle |
| rx_block_start | input | 1 | Received frame is the first of a block |
| rx_cbit | input | 1 | Received channel-status bit |
| rx_done_clr | input | 1 | Clears the block-received flag |
| rx_block_done | output | 1 | Sticky flag: full block received |
| rx_rd_sel | input | 3 | Receive word select |
| rx_rd_data | output | 32 | Selected receive word |

## Verification
On every cycle the assertions check the busy flag: it may only rise on an enabled frame strobe that loads page 0, and it may only fall on a strobe. They also check that position counters hold between strobes, that a strobe without enable stops the shifter, that the receive position restarts after a block start, that the done flag is sticky, and that out-of-range writes leave the pages alone. Only the bench scenarios show the actual bit order across the whole block, the delayed effect of a write to the page in use, and loopback agreement between transmitted and received words. They also show the exact strobe on which the done flag rises.

// File: rtl/chs_pkg.sv
package chs_pkg;
    localparam int CHS_WORD_W    = 32;
    localparam int CHS_NUM_WORDS = 6;

    typedef enum logic [2:0] {
        TX_HOLD,
        TX_STOP,
        TX_START,
        TX_SHIFT,
        TX_RELOAD
    } tx_act_e;
endpackage

// File: rtl/chs_page_regs.sv
module chs_page_regs
    import chs_pkg::*;
#(
    parameter int WORD_W    = CHS_WORD_W,
    parameter int NUM_WORDS = CHS_NUM_WORDS,
    localparam int SEL_W    = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SEL_W-1:0]                  wr_sel,
    input  logic [WORD_W-1:0]                 wr_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  pages
);
    localparam logic [SEL_W:0] NW_EXT = (SEL_W+1)'(NUM_WORDS);

    logic [NUM_WORDS-1:0][WORD_W-1:0] pages_d, pages_q;
    logic sel_ok;

    assign sel_ok = ({1'b0, wr_sel} < NW_EXT);

    always_comb begin
        pages_d = pages_q;
        if (wr_en && sel_ok) begin
            pages_d[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pages_q <= '0;
        else        pages_q <= pages_d;
    end

    assign pages = pages_q;

    // R11: a select beyond the last page leaves every page untouched
    p_oob_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_ok) |=> $stable(pages_q));
endmodule

// File: rtl/chs_tx_serializer.sv
module chs_tx_serializer
    import chs_pkg::*;
#(
    parameter int WORD_W    = CHS_WORD_W,
    parameter int NUM_WORDS = CHS_NUM_WORDS,
    localparam int SEL_W    = $clog2(NUM_WORDS),
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tx_enable,
    input  logic                              cs_enable,
    input  logic                              frame_stb,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  pages,
    output logic                              cbit,
    output logic                              busy,
    output logic                              block_first
);
    localparam logic [SEL_W-1:0] LAST_WORD = SEL_W'(NUM_WORDS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic              active;
        logic              busy;
        logic [SEL_W-1:0]  word;
        logic [BIT_W-1:0]  bitn;
        logic [WORD_W-1:0] shift;
    } tx_state_t;

    tx_state_t        st_d, st_q;
    tx_act_e          act;
    logic [SEL_W-1:0] nxt_word;

    always_comb begin
        nxt_word = (st_q.word == LAST_WORD) ? '0 : st_q.word + 1'b1;

        if (!frame_stb)                       act = TX_HOLD;
        else if (!(tx_enable && cs_enable))   act = TX_STOP;
        else if (!st_q.active)                act = TX_START;
        else if (st_q.bitn == LAST_BIT)       act = TX_RELOAD;
        else                                  act = TX_SHIFT;

        st_d = st_q;
        case (act)
            TX_STOP: begin
                st_d.active = 1'b0;
                st_d.busy   = 1'b0;
            end
            TX_START: begin
                st_d.active = 1'b1;
                st_d.busy   = 1'b1;
                st_d.word   = '0;
                st_d.bitn   = '0;
                st_d.shift  = pages[0];
            end
            TX_RELOAD: begin
                st_d.word  = nxt_word;
                st_d.bitn  = '0;
                st_d.shift = pages[nxt_word];
                if (nxt_word == '0)            st_d.busy = 1'b1;
                else if (nxt_word == LAST_WORD) st_d.busy = 1'b0;
            end
            TX_SHIFT: begin
                st_d.bitn  = st_q.bitn + 1'b1;
                st_d.shift = st_q.shift >> 1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cbit        = cs_enable & st_q.active & st_q.shift[0];
    assign busy        = st_q.busy;
    assign block_first = st_q.active && (st_q.word == '0) && (st_q.bitn == '0);

    // R3: busy only rises on an enabled strobe that leaves page 0 bit 0 loaded
    p_busy_rise_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> ($past(frame_stb && tx_enable && cs_enable)
                              && st_q.word == '0 && st_q.bitn == '0));

    // R4: busy only falls at a frame boundary
    p_busy_fall_at_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(frame_stb));

    // R4: a strobe without transmit enable idles the serializer
    p_stop_without_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !tx_enable) |=> (!st_q.active && !st_q.busy));

    // R2: a fresh start always begins at page 0 bit 0
    p_start_at_page0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> (st_q.word == '0 && st_q.bitn == '0));

    // R7: position only moves on a strobe
    p_hold_between_frames_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(st_q.bitn) && $stable(st_q.word) && $stable(st_q.shift)));
endmodule

// File: rtl/chs_rx_collector.sv
module chs_rx_collector
    import chs_pkg::*;
#(
    parameter int WORD_W    = CHS_WORD_W,
    parameter int NUM_WORDS = CHS_NUM_WORDS,
    localparam int SEL_W    = $clog2(NUM_WORDS),
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              block_start,
    input  logic              cbit_in,
    input  logic              done_clr,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              done
);
    localparam logic [SEL_W-1:0] LAST_WORD = SEL_W'(NUM_WORDS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [SEL_W:0]   NW_EXT    = (SEL_W+1)'(NUM_WORDS);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
        logic [SEL_W-1:0]                 word;
        logic [BIT_W-1:0]                 bitn;
        logic                             synced;
        logic                             done;
    } rx_state_t;

    rx_state_t        st_d, st_q;
    logic [SEL_W-1:0] wi;
    logic [BIT_W-1:0] bi;
    logic             do_write;

    always_comb begin
        wi       = block_start ? '0 : st_q.word;
        bi       = block_start ? '0 : st_q.bitn;
        do_write = frame_stb && (block_start || st_q.synced);

        st_d = st_q;
        if (done_clr) st_d.done = 1'b0;
        if (do_write) begin
            st_d.words[wi][bi] = cbit_in;
            st_d.synced        = 1'b1;
            if (bi == LAST_BIT) begin
                st_d.bitn = '0;
                st_d.word = (wi == LAST_WORD) ? '0 : wi + 1'b1;
                if (wi == LAST_WORD) st_d.done = 1'b1;
            end else begin
                st_d.bitn = bi + 1'b1;
                st_d.word = wi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = ({1'b0, rd_sel} < NW_EXT) ? st_q.words[rd_sel] : '0;
    assign done    = st_q.done;

    // R9: the flag holds until cleared
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !done_clr) |=> st_q.done);

    // R9: the flag can only be raised by a received frame
    p_done_rise_on_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(frame_stb));

    // R10: a block start puts the next write at word 0 bit 1
    p_restart_position_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && block_start) |=> (st_q.word == '0 && st_q.bitn == BIT_W'(1) && st_q.synced));

    // R10: nothing is stored before the first block start
    p_unsynced_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.synced && !block_start) |=> $stable(st_q.words));
endmodule

// File: rtl/chs_block_serdes.sv
module chs_block_serdes
    import chs_pkg::*;
#(
    parameter int WORD_W    = CHS_WORD_W,
    parameter int NUM_WORDS = CHS_NUM_WORDS,
    localparam int SEL_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [WORD_W-1:0] cfg_wr_data,
    input  logic              tx_enable,
    input  logic              cs_enable,
    input  logic              tx_frame_stb,
    output logic              tx_cbit,
    output logic              tx_busy,
    output logic              tx_block_first,
    input  logic              rx_frame_stb,
    input  logic              rx_block_start,
    input  logic              rx_cbit,
    input  logic              rx_done_clr,
    output logic              rx_block_done,
    input  logic [SEL_W-1:0]  rx_rd_sel,
    output logic [WORD_W-1:0] rx_rd_data
);
    logic [NUM_WORDS-1:0][WORD_W-1:0] pages;

    chs_page_regs #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_pages (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .pages   (pages)
    );

    chs_tx_serializer #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_enable   (tx_enable),
        .cs_enable   (cs_enable),
        .frame_stb   (tx_frame_stb),
        .pages       (pages),
        .cbit        (tx_cbit),
        .busy        (tx_busy),
        .block_first (tx_block_first)
    );

    chs_rx_collector #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb   (rx_frame_stb),
        .block_start (rx_block_start),
        .cbit_in     (rx_cbit),
        .done_clr    (rx_done_clr),
        .rd_sel      (rx_rd_sel),
        .rd_data     (rx_rd_data),
        .done        (rx_block_done)
    );

    // R5: with insertion disabled the transmitted bit is forced low
    p_cbit_low_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_enable |-> !tx_cbit);
endmodule

// File: tb/chs_block_serdes_tb.sv
`timescale 1ns/1ps
module chs_block_serdes_tb;
    localparam int BLK = 192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        tx_enable = 1'b0, cs_enable = 1'b0, tx_frame_stb = 1'b0;
    logic        tx_cbit, tx_busy, tx_block_first;
    logic        rx_frame_stb = 1'b0, rx_block_start = 1'b0, rx_cbit = 1'b0, rx_done_clr = 1'b0;
    logic        rx_block_done;
    logic [2:0]  rx_rd_sel = '0;
    logic [31:0] rx_rd_data;

    int n_run = 0, n_fail = 0;
    logic [31:0] exp_page [6];
    logic [31:0] snap;
    int  pos = 0;
    bit  act = 0, busy_m = 0;

    always #2 clk = ~clk;

    chs_block_serdes u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .tx_enable(tx_enable), .cs_enable(cs_enable), .tx_frame_stb(tx_frame_stb),
        .tx_cbit(tx_cbit), .tx_busy(tx_busy), .tx_block_first(tx_block_first),
        .rx_frame_stb(rx_frame_stb), .rx_block_start(rx_block_start), .rx_cbit(rx_cbit),
        .rx_done_clr(rx_done_clr), .rx_block_done(rx_block_done),
        .rx_rd_sel(rx_rd_sel), .rx_rd_data(rx_rd_data)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] a, input logic [63:0] e);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, a, e);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 3'(sel); cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (sel < 6) exp_page[sel] = d;
    endtask

    // one frame boundary, with the receiver looped back from the transmitter
    task automatic frame();
        @(negedge clk);
        rx_cbit = tx_cbit; rx_block_start = tx_block_first;
        tx_frame_stb = 1'b1; rx_frame_stb = 1'b1;
        @(negedge clk);
        tx_frame_stb = 1'b0; rx_frame_stb = 1'b0;
        if (!(tx_enable && cs_enable)) begin
            act = 0; busy_m = 0;
        end else begin
            if (!act) begin act = 1; pos = 0; end
            else pos = (pos + 1) % BLK;
            if (pos % 32 == 0) begin
                snap = exp_page[pos/32];
                if (pos == 0) busy_m = 1;
                else if (pos/32 == 5) busy_m = 0;
            end
        end
    endtask

    function automatic bit exp_cbit();
        return act && cs_enable && snap[pos%32];
    endfunction

    task automatic check_tx(input string tag);
        check(tx_cbit == exp_cbit(), {tag, " cbit"}, 64'(tx_cbit), 64'(exp_cbit()));
        check(tx_busy == busy_m, "R3 busy", 64'(tx_busy), 64'(busy_m));
        check(tx_block_first == (act && pos == 0), "R2 block_first",
              64'(tx_block_first), 64'(act && pos == 0));
    endtask

    task automatic rx_put(input bit start, input bit b);
        @(negedge clk);
        rx_block_start = start; rx_cbit = b; rx_frame_stb = 1'b1;
        @(negedge clk);
        rx_frame_stb = 1'b0; rx_block_start = 1'b0;
    endtask

    task automatic rd_check(input int sel, input logic [31:0] e, input string tag);
        @(negedge clk);
        rx_rd_sel = 3'(sel);
        #1;
        check(rx_rd_data == e, tag, 64'(rx_rd_data), 64'(e));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) exp_page[i] = '0;
        snap = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(tx_cbit == 0 && tx_busy == 0 && tx_block_first == 0, "R1 tx outputs",
              {61'd0, tx_cbit, tx_busy, tx_block_first}, 64'd0);
        check(rx_block_done == 0, "R1 rx done", 64'(rx_block_done), 64'd0);
        for (int i = 0; i < 6; i++) rd_check(i, 32'h0, "R1 rx word");

        for (int i = 0; i < 6; i++) wr(i, (32'h9E3779B9 * 32'(i + 3)) ^ (32'(i) << 28));
        // R11: out-of-range selects must not alias onto any page
        wr(6, 32'hDEADBEEF);
        wr(7, 32'hFFFFFFFF);

        tx_enable = 1'b1; cs_enable = 1'b1;
        // R2/R3/R6: three full blocks, each bit checked
        for (int k = 1; k <= 3*BLK + 1; k++) begin
            frame();
            check_tx("R2 R6");
            if (k == 192) check(rx_block_done == 0, "R9 done early", 64'(rx_block_done), 64'd0);
            if (k == 193) begin
                check(rx_block_done == 1, "R9 done at bit 191", 64'(rx_block_done), 64'd1);
                for (int i = 0; i < 6; i++) rd_check(i, exp_page[i], "R8 loopback word");
                rd_check(6, 32'h0, "R11 read sel 6");
                rd_check(7, 32'h0, "R11 read sel 7");
            end
            if (k == 193 + 69) begin
                // R6: page 2 is in the shifter, page 3 is not yet loaded
                wr(2, 32'h0F0F_3C3C);
                wr(3, 32'hA5A5_0001);
            end
        end

        // R7: no strobe, nothing moves
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            check_tx("R7");
        end

        // R5: insertion off forces the bit low at once
        for (int k = 0; k < 40; k++) begin
            frame();
            if (tx_cbit == 1'b1) break;
        end
        check(tx_cbit == 1, "R5 setup", 64'(tx_cbit), 64'd1);
        @(negedge clk);
        cs_enable = 1'b0;
        #1;
        check(tx_cbit == 0, "R5 cbit forced low", 64'(tx_cbit), 64'd0);
        check(tx_busy == busy_m, "R4 busy held until frame end", 64'(tx_busy), 64'(busy_m));
        frame();
        check_tx("R4 stop on cs off");
        check(tx_busy == 0, "R4 busy cleared", 64'(tx_busy), 64'd0);
        cs_enable = 1'b1;
        frame();
        check_tx("R4 restart");
        check(tx_block_first == 1 && tx_busy == 1, "R4 restart at page 0 bit 0",
              {62'd0, tx_block_first, tx_busy}, 64'd3);
        for (int k = 0; k < 50; k++) begin
            frame();
            check_tx("R2");
        end

        // R4: transmit enable removed, busy lasts until the frame end
        @(negedge clk);
        tx_enable = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_busy == 1, "R4 busy before frame end", 64'(tx_busy), 64'd1);
        frame();
        check_tx("R4 stop");

        // R9: clear
        @(negedge clk);
        rx_done_clr = 1'b1;
        @(negedge clk);
        rx_done_clr = 1'b0;
        check(rx_block_done == 0, "R9 cleared", 64'(rx_block_done), 64'd0);

        // R10: fresh receiver, manual stream
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rx_put(0, 1); rx_put(0, 1); rx_put(0, 1);
        rd_check(0, 32'h0, "R10 ignored before sync");
        rx_put(1, 1); rx_put(0, 0); rx_put(0, 1); rx_put(0, 1);
        rd_check(0, 32'h0000_000D, "R8 R10 first bits");
        rx_put(1, 0); rx_put(0, 1);
        rd_check(0, 32'h0000_000E, "R10 restart mid block");
        rd_check(1, 32'h0, "R10 other word untouched");
        check(rx_block_done == 0, "R9 not done", 64'(rx_block_done), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule